// File: doc/BRIEF.md
# Pointer-Addressed Port I/O Unit

This block carries out the port input and port output operations of a byte-wide accumulator processor. The surrounding core fetches an opcode and hands it over on a command stream. The unit then moves one byte between the external 8-bit port bus and memory. The memory address always comes from the 16-bit pointer register that the core currently selects as its data pointer. The core supplies the value of that pointer and applies the update that the unit returns.

An output operation reads the byte at the pointer address, presents it on the port bus with a one-cycle output strobe, and then advances the pointer by one. An input operation raises a one-cycle input strobe and samples the bus at the end of that cycle. It then writes the byte both to the accumulator and to memory at the pointer address, and leaves the pointer unchanged. While an I/O operation runs, the three-bit port-select output carries the low three opcode bits. The output code with port field zero is a bare pointer increment. The input code with port field zero, and every opcode outside the group, is reported as illegal.

The command interface is valid/ready. `cmd_ready` is high only while the unit is idle, and an opcode is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The core must hold `cmd_op` stable while `cmd_valid` is high and `cmd_ready` is low. A `done` pulse marks the last cycle of every accepted command. The memory port always accepts a request, and read data returns one cycle after `mem_re`.

Top module: `pio_xunit`

## Requirements
- R1: `cmd_ready` is high exactly when the unit is idle: after reset, and again from the cycle after `done`. It is low in every cycle of a command, from the cycle after acceptance through the `done` cycle.
- R2: For an output opcode 0x61 to 0x67, the unit asserts `mem_re` once with `mem_addr` equal to `rx_val`. Two cycles later it raises `out_stb` for exactly one cycle, with `io_dout` equal to the byte read. No memory write and no accumulator write occurs.
- R3: In the `out_stb` cycle of an output opcode, the unit asserts `rx_we` with `rx_next` = `rx_val` + 1 modulo 2^16, so 0xFFFF wraps to 0x0000.
- R4: For an input opcode 0x69 to 0x6F, the unit raises `in_stb` for one cycle and samples `io_din` at the end of that cycle. In the next cycle it asserts `mem_we` (address `rx_val`) and `d_we`, and both `mem_wdata` and `d_wdata` carry the sampled byte. A later change of `io_din` has no effect.
- R5: An input opcode never asserts `rx_we`.
- R6: `io_sel` equals bits [2:0] of the accepted opcode in every cycle of an I/O command (0x60 to 0x6F, except 0x68). It is 0 when idle and while an illegal opcode is reported.
- R7: Opcode 0x60 asserts `rx_we` with `rx_next` = `rx_val` + 1 in the cycle after acceptance. It raises no strobe and makes no memory access.
- R8: Opcode 0x68, and any opcode whose upper four bits are not 0x6, raises `illegal` for one cycle, the cycle after acceptance. It has no other effect: no strobe, no memory access, no accumulator or pointer write.
- R9: `done` is a one-cycle pulse in the final cycle of every command. That cycle is 0 cycles after the first busy cycle for 0x60 and for illegal opcodes, 1 cycle after it for input, and 2 cycles after it for output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Opcode offered |
| cmd_ready | output | 1 | Unit idle, opcode will be taken |
| cmd_op | input | 8 | Opcode |
| done | output | 1 | Last cycle of a command |
| illegal | output | 1 | Opcode not executable by this unit |
| mem_addr | output | 16 | Memory byte address (pointer value) |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |
| io_sel | output | 3 | Port select |
| io_dout | output | 8 | Port bus output byte |
| io_din | input | 8 | Port bus input byte |
| out_stb | output | 1 | Output strobe |
| in_stb | output | 1 | Input strobe |
| rx_val | input | 16 | Current data pointer value |
| rx_we | output | 1 | Pointer update request |
| rx_next | output | 16 | New pointer value |
| d_we | output | 1 | Accumulator write request |
| d_wdata | output | 8 | Accumulator write byte |

## Verification
The bench sweeps all 256 opcodes at pointer values that include 0xFFFF, so both the 0x60 and 0x68 codes and the borders of the group are covered. A unit that treated 0x68 as an input would strobe the bus and write memory instead of flagging it. A unit that treated 0x60 as an output would strobe the bus. Pointer wrap-around catches an increment that is too narrow. The bench changes `io_din` right after the input strobe and returns mismatched garbage outside the read window. It also replaces `cmd_op` after acceptance, so a design that samples the bus late or does not latch the opcode shows up as wrong data or a wrong select.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ORD, ST_OLAT, ST_OSTB, ST_PINC, ST_ISTB, ST_IWR, ST_ILL
  } pio_st_e;

  typedef enum logic [1:0] {
    K_ILL, K_OUT, K_IN, K_INC
  } pio_kind_e;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int unsigned OPW = 8,
  parameter int unsigned PW  = 3,
  parameter logic [OPW-PW-2:0] GRP = 'h6
) (
  input  logic [OPW-1:0] op,
  output pio_kind_e      kind
);
  localparam int unsigned GW = OPW - PW - 1;

  logic [GW-1:0] grp;
  logic          dir_in;
  logic [PW-1:0] port;

  assign grp    = op[OPW-1:PW+1];
  assign dir_in = op[PW];
  assign port   = op[PW-1:0];

  always_comb begin
    if (grp != GRP)        kind = K_ILL;
    else if (!dir_in)      kind = (port == '0) ? K_INC : K_OUT;
    else                   kind = (port == '0) ? K_ILL : K_IN;
  end
endmodule

// File: rtl/pio_ptr_inc.sv
module pio_ptr_inc #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_nxt
);
  assign ptr_nxt = ptr + {{(AW-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  pio_kind_e     kind,
  input  logic [PW-1:0] port_in,
  output logic          done,
  output logic          illegal,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [PW-1:0] io_sel,
  output logic [DW-1:0] io_dout,
  input  logic [DW-1:0] io_din,
  output logic          out_stb,
  output logic          in_stb,
  output logic          rx_we,
  output logic          d_we,
  output logic [DW-1:0] d_wdata
);
  pio_st_e       st;
  logic [PW-1:0] port_q;
  logic [DW-1:0] bus_q;
  logic [DW-1:0] in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      port_q <= '0;
      bus_q  <= '0;
      in_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          port_q <= port_in;
          unique case (kind)
            K_OUT:   st <= ST_ORD;
            K_IN:    st <= ST_ISTB;
            K_INC:   st <= ST_PINC;
            default: st <= ST_ILL;
          endcase
        end
        ST_ORD:  st <= ST_OLAT;
        ST_OLAT: begin
          bus_q <= mem_rdata;
          st    <= ST_OSTB;
        end
        ST_ISTB: begin
          in_q <= io_din;
          st   <= ST_IWR;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign mem_re    = (st == ST_ORD);
  assign out_stb   = (st == ST_OSTB);
  assign in_stb    = (st == ST_ISTB);
  assign mem_we    = (st == ST_IWR);
  assign d_we      = (st == ST_IWR);
  assign rx_we     = (st == ST_OSTB) || (st == ST_PINC);
  assign illegal   = (st == ST_ILL);
  assign done      = (st == ST_OSTB) || (st == ST_PINC) ||
                     (st == ST_IWR)  || (st == ST_ILL);
  assign io_dout   = bus_q;
  assign mem_wdata = in_q;
  assign d_wdata   = in_q;
  assign io_sel    = (st == ST_IDLE || st == ST_ILL) ? '0 : port_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R1
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_stb && in_stb)); // R2
  AST_OSTB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |=> !out_stb); // R2
  AST_READ_TO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !out_stb && !mem_re); // R2
  AST_OUT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> rx_we); // R3
  AST_IN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> (mem_we && d_we)); // R4
  AST_IN_NO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb || mem_we) |-> !rx_we); // R5
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (io_sel == '0)); // R6
  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(out_stb || in_stb || mem_re || mem_we || rx_we || d_we)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready)); // R9
endmodule

// File: rtl/pio_xunit.sv
module pio_xunit
  import pio_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 16,
  parameter int unsigned OPW = 8,
  parameter int unsigned PW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [OPW-1:0] cmd_op,
  output logic           done,
  output logic           illegal,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_re,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [PW-1:0]  io_sel,
  output logic [DW-1:0]  io_dout,
  input  logic [DW-1:0]  io_din,
  output logic           out_stb,
  output logic           in_stb,
  input  logic [AW-1:0]  rx_val,
  output logic           rx_we,
  output logic [AW-1:0]  rx_next,
  output logic           d_we,
  output logic [DW-1:0]  d_wdata
);
  pio_kind_e kind;

  pio_decode #(.OPW(OPW), .PW(PW)) dec_i (
    .op   (cmd_op),
    .kind (kind)
  );

  pio_ptr_inc #(.AW(AW)) inc_i (
    .ptr     (rx_val),
    .ptr_nxt (rx_next)
  );

  pio_ctrl #(.DW(DW), .PW(PW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .kind      (kind),
    .port_in   (cmd_op[PW-1:0]),
    .done      (done),
    .illegal   (illegal),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .io_sel    (io_sel),
    .io_dout   (io_dout),
    .io_din    (io_din),
    .out_stb   (out_stb),
    .in_stb    (in_stb),
    .rx_we     (rx_we),
    .d_we      (d_we),
    .d_wdata   (d_wdata)
  );

  assign mem_addr = rx_val;
endmodule

// File: tb/pio_xunit_tb_top.sv
module pio_xunit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = 8'h00;
  logic        done, illegal;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [2:0]  io_sel;
  logic [7:0]  io_dout;
  logic [7:0]  io_din = 8'h00;
  logic        out_stb, in_stb;
  logic [15:0] rx_val = 16'h0000;
  logic        rx_we;
  logic [15:0] rx_next;
  logic        d_we;
  logic [7:0]  d_wdata;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pio_xunit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .done(done), .illegal(illegal), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .io_sel(io_sel), .io_dout(io_dout),
    .io_din(io_din), .out_stb(out_stb), .in_stb(in_stb), .rx_val(rx_val),
    .rx_we(rx_we), .rx_next(rx_next), .d_we(d_we), .d_wdata(d_wdata)
  );

  function automatic logic [7:0] mfun(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5C;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [15:0] rx,
                        input logic [7:0] din);
    int n_o = 0, n_i = 0, n_mw = 0, n_dw = 0, n_rw = 0, n_ill = 0;
    int n_mr = 0, n_done = 0, lat = 0;
    logic [7:0]  bus = 8'h00, mwd = 8'h00, dwd = 8'h00;
    logic [15:0] mwa = 16'h0, rxn = 16'h0;
    bit sel_bad = 0, addr_bad = 0, ready_bad = 0;
    bit is_grp, is_ill, is_inc, is_out, is_in;
    logic [2:0] esel;
    int exp_lat;
    is_grp = (op[7:4] == 4'h6);
    is_ill = !is_grp || (op == 8'h68);
    is_inc = (op == 8'h60);
    is_out = is_grp && !op[3] && (op[2:0] != 3'd0);
    is_in  = is_grp && op[3] && (op[2:0] != 3'd0);
    esel   = is_ill ? 3'd0 : op[2:0];
    exp_lat = is_out ? 2 : (is_in ? 1 : 0);

    cmd_op = op; rx_val = rx; io_din = din; mem_rdata = ~mfun(rx);
    cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R1 ready when idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = ~op;
    for (int c = 0; c < 10; c++) begin
      if (n_i > 0) io_din = ~din;
      if (cmd_ready) ready_bad = 1;
      if (io_sel != esel) sel_bad = 1;
      if (mem_re) begin
        n_mr++;
        if (mem_addr != rx) addr_bad = 1;
        mem_rdata = mfun(mem_addr);
      end
      if (out_stb) begin n_o++; bus = io_dout; end
      if (in_stb) n_i++;
      if (mem_we) begin n_mw++; mwa = mem_addr; mwd = mem_wdata; end
      if (d_we) begin n_dw++; dwd = d_wdata; end
      if (rx_we) begin n_rw++; rxn = rx_next; end
      if (illegal) n_ill++;
      if (done) begin n_done++; lat = c; break; end
      @(negedge clk);
    end
    chk(n_done == 1, "R9 done seen", n_done, 1);
    chk(lat == exp_lat, "R9 latency", lat, exp_lat);
    chk(!ready_bad, "R1 ready low while busy", ready_bad, 0);
    chk(!sel_bad, "R6 select during command", op, esel);
    if (is_ill) begin
      chk(n_ill == 1, "R8 illegal flag", n_ill, 1);
      chk(n_o + n_i + n_mw + n_dw + n_rw + n_mr == 0, "R8 no side effect",
          n_o + n_i + n_mw + n_dw + n_rw + n_mr, 0);
    end else begin
      chk(n_ill == 0, "R8 legal opcode not flagged", n_ill, 0);
    end
    if (is_inc) begin
      chk(n_rw == 1 && rxn == 16'(rx + 16'd1), "R7 pointer increment", rxn, 16'(rx + 16'd1));
      chk(n_o + n_i + n_mw + n_dw + n_mr == 0, "R7 no strobe or access",
          n_o + n_i + n_mw + n_dw + n_mr, 0);
    end
    if (is_out) begin
      chk(n_o == 1, "R2 one output strobe", n_o, 1);
      chk(n_mr == 1 && !addr_bad, "R2 read at pointer", n_mr, 1);
      chk(bus == mfun(rx), "R2 output byte", bus, mfun(rx));
      chk(n_mw + n_dw + n_i == 0, "R2 no write", n_mw + n_dw + n_i, 0);
      chk(n_rw == 1 && rxn == 16'(rx + 16'd1), "R3 pointer advance", rxn, 16'(rx + 16'd1));
    end
    if (is_in) begin
      chk(n_i == 1, "R4 one input strobe", n_i, 1);
      chk(n_mw == 1 && mwa == rx && mwd == din, "R4 memory write", {mwa, mwd}, {rx, din});
      chk(n_dw == 1 && dwd == din, "R4 accumulator write", dwd, din);
      chk(n_o + n_mr == 0, "R4 no output", n_o + n_mr, 0);
      chk(n_rw == 0, "R5 pointer kept", n_rw, 0);
    end
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after done", cmd_ready, 1);
    chk(io_sel == 3'd0, "R6 select idle", io_sel, 0);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(io_sel == 3'd0, "R6 select zero after reset", io_sel, 0);
    chk(!out_stb && !in_stb && !done && !illegal, "R9 quiet after reset",
        {out_stb, in_stb, done, illegal}, 0);
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 256; o++) begin
        logic [15:0] rx;
        rx = (p == 0) ? 16'(16'h1234 + o * 16'd257) : ((p == 1) ? 16'hFFFF : 16'h00FF);
        run_op(8'(o), rx, 8'(o * 3 + p * 77));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule